// File: doc/BRIEF.md
# Rotor-Driven Three-Axis Vector Rotator

This block turns a three-component vector by the rotation that a rotor describes. The rotor holds a scalar part `s` and three bivector parts `b12`, `b13` and `b23`, attached to the planes e1e2, e1e3 and e2e3. The block forms the sandwich product R·v·R̃. Here R̃ is the reverse of the rotor: the scalar is kept and every bivector part is negated. All numbers are signed 32-bit values with 16 fraction bits.

One bank of nine multipliers does all the work, in two phases. In the first phase the bank forms the four rotor squares and the six cross products over two cycles. A coefficient stage turns these into the nine entries of the equivalent rotation matrix. In the second phase the same bank multiplies each matrix entry by its vector component. A two-level adder tree then gives the three output components.

A caller drives the rotor and the vector, then pulses `start`. The caller waits for the one-cycle `done` pulse and reads the result. The result stays on the outputs until the next rotation finishes.

Top module: `rotor_vec_rotator`

## Requirements
- R1: After reset, `busy` and `done` are low and all three result outputs are zero.
- R2: A `start` seen while the block is idle is accepted on that clock edge. `busy` is high for the next seven cycles. `done` is high in the eighth cycle, that is, seven clock edges after the accepting edge.
- R3: `done` lasts exactly one cycle, and `busy` is low whenever `done` is high.
- R4: A `start` that arrives while `busy` is high is ignored. It does not change the running result, and it does not produce an extra `done` pulse.
- R5: The result equals M·v, and every element of the calculation wraps to 32 bits. Each product is the full 64-bit product shifted right arithmetically by 16 and truncated to 32 bits. With squares sXX = s·s, s1 = b12², s2 = b13², s3 = b23², and crosses cAB, the matrix is:
  - row x: (sXX−s1−s2+s3, 2(c01−c23), 2(c02+c13))
  - row y: (−2(c01+c23), sXX−s1+s2−s3, 2(c03−c12))
  - row z: (2(c13−c02), −2(c12+c03), sXX+s1−s2−s3)
  - Index 0 is `s`, 1 is `b12`, 2 is `b13`, 3 is `b23`.
  - Each output component is the sum of three Q16.16 products.
- R6: The identity rotor (`s` = 0x0001_0000, all bivector parts zero) returns the input vector unchanged.
- R7: Between two `done` pulses the result outputs do not change, whatever the inputs do.
- R8: The sign conventions follow the plane order e12, e13, e23. A pure e23 rotor (`b23` = 0x0001_0000, other parts zero) keeps the x component and negates the y and z components.
- R9: The rotor and vector are sampled only on the accepting edge. Changing them while `busy` is high does not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a rotation when idle |
| rot_s | input | 32 | Rotor scalar part, Q16.16 |
| rot_b12 | input | 32 | Rotor e1e2 part, Q16.16 |
| rot_b13 | input | 32 | Rotor e1e3 part, Q16.16 |
| rot_b23 | input | 32 | Rotor e2e3 part, Q16.16 |
| vec_x | input | 32 | Input e1 component, Q16.16 |
| vec_y | input | 32 | Input e2 component, Q16.16 |
| vec_z | input | 32 | Input e3 component, Q16.16 |
| busy | output | 1 | Rotation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_x | output | 32 | Rotated e1 component |
| res_y | output | 32 | Rotated e2 component |
| res_z | output | 32 | Rotated e3 component |

## Verification
The hardest states to reach from the ports are those where the inputs move while the shared multiplier bank is between its two phases. A second `start` or changed operands could then leak into the second phase or into the adder tree. The stimulus reaches these states in two ways. It raises a stray `start` with junk operands in the middle of a run, and it rewrites every operand right after acceptance. In both cases the result must still match the operands captured at the start, and only one `done` pulse may appear. Random unit rotors, an identity rotor and a half-turn in the e23 plane test the sign pattern of every matrix entry against a bit-exact Q16.16 model.

// File: rtl/rot_pkg.sv
package rot_pkg;
   localparam int ROT_DIM  = 3;
   localparam int ROT_NMUL = ROT_DIM * ROT_DIM;
   localparam int ROT_NSQ  = 4;
   localparam int ROT_NCR  = 6;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_P1A,
      ST_P1B,
      ST_MAT,
      ST_P2,
      ST_ADD1,
      ST_ADD2,
      ST_OUT
   } rot_state_e;
endpackage

// File: rtl/rot_mulbank.sv
module rot_mulbank #(
   parameter int W     = 32,
   parameter int FRAC  = 16,
   parameter int N     = 9,
   parameter bit ROUND = 1'b0
) (
   input  logic signed [W-1:0] op_a [N],
   input  logic signed [W-1:0] op_b [N],
   output logic signed [W-1:0] prod [N]
);
   localparam int PW = 2 * W;
   localparam logic signed [PW-1:0] HALF =
      {{(PW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};

   for (genvar i = 0; i < N; i++) begin : g_mul
      logic signed [PW-1:0] full;
      assign full = PW'(op_a[i]) * PW'(op_b[i]);
      if (ROUND) begin : g_rnd
         assign prod[i] = W'((full + HALF) >>> FRAC);
      end else begin : g_trunc
         assign prod[i] = W'(full >>> FRAC);
      end
   end
endmodule

// File: rtl/rot_coef.sv
module rot_coef #(
   parameter int W = 32
) (
   input  logic signed [W-1:0] sq  [rot_pkg::ROT_NSQ],
   input  logic signed [W-1:0] cr  [rot_pkg::ROT_NCR],
   output logic signed [W-1:0] mat [rot_pkg::ROT_NMUL]
);
   // cross index: 0=c01 1=c02 2=c03 3=c12 4=c13 5=c23
   logic signed [W-1:0] c01, c02, c03, c12, c13, c23;
   assign c01 = cr[0];
   assign c02 = cr[1];
   assign c03 = cr[2];
   assign c12 = cr[3];
   assign c13 = cr[4];
   assign c23 = cr[5];

   always_comb begin
      mat[0] = sq[0] - sq[1] - sq[2] + sq[3];
      mat[1] = (c01 - c23) <<< 1;
      mat[2] = (c02 + c13) <<< 1;
      mat[3] = -((c01 + c23) <<< 1);
      mat[4] = sq[0] - sq[1] + sq[2] - sq[3];
      mat[5] = (c03 - c12) <<< 1;
      mat[6] = (c13 - c02) <<< 1;
      mat[7] = -((c12 + c03) <<< 1);
      mat[8] = sq[0] + sq[1] - sq[2] - sq[3];
   end
endmodule

// File: rtl/rot_dotsum.sv
module rot_dotsum #(
   parameter int W    = 32,
   parameter int NDIM = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_pair,
   input  logic               en_fin,
   input  logic signed [W-1:0] prod [NDIM*NDIM],
   output logic signed [W-1:0] sum  [NDIM]
);
   for (genvar r = 0; r < NDIM; r++) begin : g_row
      logic signed [W-1:0] head_c, head_r, tail_r, sum_r;
      always_comb begin
         head_c = '0;
         for (int k = 0; k < NDIM - 1; k++) head_c = head_c + prod[r*NDIM+k];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            head_r <= '0;
            tail_r <= '0;
            sum_r  <= '0;
         end else begin
            if (en_pair) begin
               head_r <= head_c;
               tail_r <= prod[r*NDIM+NDIM-1];
            end
            if (en_fin) sum_r <= head_r + tail_r;
         end
      end
      assign sum[r] = sum_r;
   end
endmodule

// File: rtl/rotor_vec_rotator.sv
module rotor_vec_rotator #(
   parameter int W     = 32,
   parameter int FRAC  = 16,
   parameter bit ROUND = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] rot_s,
   input  logic [W-1:0] rot_b12,
   input  logic [W-1:0] rot_b13,
   input  logic [W-1:0] rot_b23,
   input  logic [W-1:0] vec_x,
   input  logic [W-1:0] vec_y,
   input  logic [W-1:0] vec_z,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] res_x,
   output logic [W-1:0] res_y,
   output logic [W-1:0] res_z
);
   import rot_pkg::*;

   localparam int NDIM = ROT_DIM;
   localparam int NMUL = ROT_NMUL;

   initial begin : elab_chk
      assert (FRAC > 0 && FRAC < W) else $fatal(1, "FRAC out of range");
      assert (W >= 8) else $fatal(1, "W too small");
      assert (NMUL >= ROT_NSQ + ROT_NCR - 1) else $fatal(1, "bank too small");
   end

   rot_state_e state;
   logic accept;
   logic signed [W-1:0] q_r   [ROT_NSQ];
   logic signed [W-1:0] v_r   [NDIM];
   logic signed [W-1:0] prod_r[NMUL];
   logic signed [W-1:0] c23_r;
   logic signed [W-1:0] mat_r [NMUL];
   logic signed [W-1:0] mul_a [NMUL];
   logic signed [W-1:0] mul_b [NMUL];
   logic signed [W-1:0] mul_p [NMUL];
   logic signed [W-1:0] sq_c  [ROT_NSQ];
   logic signed [W-1:0] cr_c  [ROT_NCR];
   logic signed [W-1:0] mat_c [NMUL];
   logic signed [W-1:0] sum_c [NDIM];
   logic signed [W-1:0] res_r [NDIM];
   logic done_r;

   assign busy   = (state != ST_IDLE);
   assign accept = start && !busy;

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         done_r <= 1'b0;
      end else begin
         done_r <= 1'b0;
         unique case (state)
            ST_IDLE: if (accept) state <= ST_P1A;
            ST_P1A:  state <= ST_P1B;
            ST_P1B:  state <= ST_MAT;
            ST_MAT:  state <= ST_P2;
            ST_P2:   state <= ST_ADD1;
            ST_ADD1: state <= ST_ADD2;
            ST_ADD2: state <= ST_OUT;
            ST_OUT: begin
               state  <= ST_IDLE;
               done_r <= 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // operand capture on the accepting edge only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ROT_NSQ; i++) q_r[i] <= '0;
         for (int i = 0; i < NDIM; i++) v_r[i] <= '0;
      end else if (accept) begin
         q_r[0] <= rot_s;
         q_r[1] <= rot_b12;
         q_r[2] <= rot_b13;
         q_r[3] <= rot_b23;
         v_r[0] <= vec_x;
         v_r[1] <= vec_y;
         v_r[2] <= vec_z;
      end
   end

   // shared multiplier bank operand routing per phase
   always_comb begin
      for (int i = 0; i < NMUL; i++) begin
         mul_a[i] = '0;
         mul_b[i] = '0;
      end
      unique case (state)
         ST_P1A: begin
            for (int i = 0; i < ROT_NSQ; i++) begin
               mul_a[i] = q_r[i];
               mul_b[i] = q_r[i];
            end
            mul_a[4] = q_r[0]; mul_b[4] = q_r[1];
            mul_a[5] = q_r[0]; mul_b[5] = q_r[2];
            mul_a[6] = q_r[0]; mul_b[6] = q_r[3];
            mul_a[7] = q_r[1]; mul_b[7] = q_r[2];
            mul_a[8] = q_r[1]; mul_b[8] = q_r[3];
         end
         ST_P1B: begin
            mul_a[0] = q_r[2];
            mul_b[0] = q_r[3];
         end
         ST_P2: begin
            for (int r = 0; r < NDIM; r++)
               for (int c = 0; c < NDIM; c++) begin
                  mul_a[r*NDIM+c] = mat_r[r*NDIM+c];
                  mul_b[r*NDIM+c] = v_r[c];
               end
         end
         default: ;
      endcase
   end

   rot_mulbank #(.W(W), .FRAC(FRAC), .N(NMUL), .ROUND(ROUND)) mulbank_i (
      .op_a (mul_a),
      .op_b (mul_b),
      .prod (mul_p)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NMUL; i++) prod_r[i] <= '0;
         c23_r <= '0;
      end else begin
         if (state == ST_P1A || state == ST_P2)
            for (int i = 0; i < NMUL; i++) prod_r[i] <= mul_p[i];
         if (state == ST_P1B) c23_r <= mul_p[0];
      end
   end

   // rotation coefficient stage
   always_comb begin
      for (int i = 0; i < ROT_NSQ; i++) sq_c[i] = prod_r[i];
      for (int i = 0; i < ROT_NCR - 1; i++) cr_c[i] = prod_r[ROT_NSQ+i];
      cr_c[ROT_NCR-1] = c23_r;
   end

   rot_coef #(.W(W)) coef_i (
      .sq  (sq_c),
      .cr  (cr_c),
      .mat (mat_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NMUL; i++) mat_r[i] <= '0;
      end else if (state == ST_MAT) begin
         for (int i = 0; i < NMUL; i++) mat_r[i] <= mat_c[i];
      end
   end

   rot_dotsum #(.W(W), .NDIM(NDIM)) dotsum_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_pair (state == ST_ADD1),
      .en_fin  (state == ST_ADD2),
      .prod    (prod_r),
      .sum     (sum_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NDIM; i++) res_r[i] <= '0;
      end else if (state == ST_OUT) begin
         for (int i = 0; i < NDIM; i++) res_r[i] <= sum_c[i];
      end
   end

   assign done  = done_r;
   assign res_x = res_r[0];
   assign res_y = res_r[1];
   assign res_z = res_r[2];

   // R2: acceptance raises busy, done follows seven edges after acceptance
   p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy);
   p_done_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(accept, 8));
   // R3: single-cycle pulse, never together with busy
   p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R9 (and R4): captured operands frozen while a rotation runs
   p_ops_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(q_r[0]) && $stable(q_r[3]) && $stable(v_r[0]) && $stable(v_r[2])));
   // R7: results change only together with done
   p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(res_x) && $stable(res_y) && $stable(res_z)));
endmodule

// File: tb/rotor_vec_rotator_tb_top.sv
module rotor_vec_rotator_tb_top;
   localparam int ONE = 32'h0001_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [31:0] rot_s = '0, rot_b12 = '0, rot_b13 = '0, rot_b23 = '0;
   logic [31:0] vec_x = '0, vec_y = '0, vec_z = '0;
   logic busy, done;
   logic [31:0] res_x, res_y, res_z;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #10ns clk = ~clk;

   rotor_vec_rotator dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .rot_s(rot_s), .rot_b12(rot_b12), .rot_b13(rot_b13), .rot_b23(rot_b23),
      .vec_x(vec_x), .vec_y(vec_y), .vec_z(vec_z),
      .busy(busy), .done(done), .res_x(res_x), .res_y(res_y), .res_z(res_z)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int mq(input int x, input int y);
      longint f;
      f = longint'(x) * longint'(y);
      return int'(f >>> 16);
   endfunction

   // bit-exact model from R5
   task automatic model(input int q0, q1, q2, q3, ax, ay, az,
                        output int ex, ey, ez);
      int s0, s1, s2, s3, c01, c02, c03, c12, c13, c23;
      int m [9];
      s0 = mq(q0, q0); s1 = mq(q1, q1); s2 = mq(q2, q2); s3 = mq(q3, q3);
      c01 = mq(q0, q1); c02 = mq(q0, q2); c03 = mq(q0, q3);
      c12 = mq(q1, q2); c13 = mq(q1, q3); c23 = mq(q2, q3);
      m[0] = s0 - s1 - s2 + s3;   m[1] = 2 * (c01 - c23);  m[2] = 2 * (c02 + c13);
      m[3] = -2 * (c01 + c23);    m[4] = s0 - s1 + s2 - s3; m[5] = 2 * (c03 - c12);
      m[6] = 2 * (c13 - c02);     m[7] = -2 * (c12 + c03); m[8] = s0 + s1 - s2 - s3;
      ex = mq(m[0], ax) + mq(m[1], ay) + mq(m[2], az);
      ey = mq(m[3], ax) + mq(m[4], ay) + mq(m[5], az);
      ez = mq(m[6], ax) + mq(m[7], ay) + mq(m[8], az);
   endtask

   // mode 0 plain, 1 stray start with junk mid-run (R4), 2 operands rewritten (R9)
   task automatic run_rot(input int q0, q1, q2, q3, ax, ay, az, input int mode,
                          input string req);
      int ex, ey, ez;
      int first_done;
      model(q0, q1, q2, q3, ax, ay, az, ex, ey, ez);
      @(negedge clk);
      rot_s = q0; rot_b12 = q1; rot_b13 = q2; rot_b23 = q3;
      vec_x = ax; vec_y = ay; vec_z = az;
      start = 1'b1;
      first_done = 0;
      for (int i = 1; i <= 12; i++) begin
         @(negedge clk);
         if (i == 1) start = 1'b0;
         if (mode == 2 && i == 1) begin
            rot_s = 32'h1234_5678; rot_b12 = 32'h0badf00d; rot_b13 = 32'h7;
            rot_b23 = 32'hffff_0000; vec_x = 32'h4000_0000; vec_y = 32'h5; vec_z = 32'h9;
         end
         if (mode == 1 && i == 3) begin
            rot_s = 32'h0; rot_b23 = ONE; vec_x = 32'h0100_0000;
            start = 1'b1;
         end
         if (mode == 1 && i == 4) start = 1'b0;
         if (i <= 7) chk(busy == 1'b1 && done == 1'b0, "R2", "busy phase", busy, 1);
         if (i == 8) begin
            chk(done == 1'b1, "R2", "done at 7 edges after accept", done, 1);
            chk(busy == 1'b0, "R3", "busy low with done", busy, 0);
            first_done = 1;
         end
         if (i > 8) chk(done == 1'b0, (mode == 1) ? "R4" : "R3", "no extra done", done, 0);
      end
      chk(res_x == ex, req, "res_x", int'(res_x), ex);
      chk(res_y == ey, req, "res_y", int'(res_y), ey);
      chk(res_z == ez, req, "res_z", int'(res_z), ez);
      if (first_done == 0) chk(1'b0, "R2", "done missing", 0, 1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stim
      int hx, hy, hz;
      void'($urandom(32'h5eed_c0de));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy == 0, "R1", "busy in reset", busy, 0);
      chk(done == 0, "R1", "done in reset", done, 0);
      chk(res_x == 0 && res_y == 0 && res_z == 0, "R1", "result in reset", int'(res_x), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 0 && done == 0, "R1", "idle after reset", busy, 0);

      // R6 identity rotor
      run_rot(ONE, 0, 0, 0, 32'h0003_8000, -32'sh0001_2000, 32'h0100_0000, 0, "R6");
      chk(res_x == 32'h0003_8000, "R6", "x passthrough", int'(res_x), 32'h0003_8000);
      chk(res_z == 32'h0100_0000, "R6", "z passthrough", int'(res_z), 32'h0100_0000);

      // R8 half-turn in e23 plane
      run_rot(0, 0, 0, ONE, 32'h0002_0000, 32'h0005_0000, -32'sh0007_0000, 0, "R8");
      chk(int'(res_x) == 32'h0002_0000, "R8", "x kept", int'(res_x), 32'h0002_0000);
      chk(int'(res_y) == -32'sh0005_0000, "R8", "y negated", int'(res_y), -32'sh0005_0000);
      chk(int'(res_z) == 32'h0007_0000, "R8", "z negated", int'(res_z), 32'h0007_0000);

      // R5 quarter turn in e12 plane: e1 -> (0,-1,0) per sign convention
      run_rot(32'h0000_B505, 32'h0000_B505, 0, 0, ONE, 0, 0, 0, "R5");

      // R4 stray start during busy
      run_rot(32'h0000_DDB4, 0, 32'h0000_8000, 0, 32'h0010_0000, 32'h0020_0000, -32'sh0003_0000, 1, "R4");
      // R9 operand changes during busy
      run_rot(32'h0000_DDB4, 0, 0, 32'h0000_8000, -32'sh0011_0000, 32'h0002_4000, 32'h0009_0000, 2, "R9");

      // R7 outputs hold while inputs move without start
      hx = int'(res_x); hy = int'(res_y); hz = int'(res_z);
      rot_s = 32'h0; rot_b12 = ONE; vec_x = 32'h7fff_0000; vec_y = 32'h1; vec_z = 32'h2;
      repeat (6) @(negedge clk);
      chk(int'(res_x) == hx && int'(res_y) == hy && int'(res_z) == hz, "R7",
          "result held", int'(res_x), hx);
      chk(busy == 0, "R7", "no run without start", busy, 0);

      // R5 random unit rotors
      for (int n = 0; n < 40; n++) begin
         real r [4];
         real nrm;
         int qv [4];
         int vx, vy, vz;
         nrm = 0.0;
         for (int k = 0; k < 4; k++) begin
            r[k] = real'(int'($urandom_range(0, 2000)) - 1000) / 1000.0;
            nrm = nrm + r[k] * r[k];
         end
         if (nrm < 0.0001) begin
            r[0] = 1.0; nrm = 1.0;
         end
         nrm = $sqrt(nrm);
         for (int k = 0; k < 4; k++) qv[k] = $rtoi(r[k] / nrm * 65536.0);
         vx = int'($urandom_range(0, 131072000)) - 65536000;
         vy = int'($urandom_range(0, 131072000)) - 65536000;
         vz = int'($urandom_range(0, 131072000)) - 65536000;
         run_rot(qv[0], qv[1], qv[2], qv[3], vx, vy, vz, (n % 8 == 3) ? 1 : 0, "R5");
      end

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule